// File: doc/BRIEF.md
# Early Receive Interrupt Generator

This block sits beside a receive path and watches the bytes of each incoming Ethernet frame. From the length information carried inside the frame, it works out how many bytes the frame will have. It then raises a one-cycle early-receive pulse once the running byte count comes within a programmed distance of that end. A driver can use the pulse to start fetching the frame before reception completes. The block also produces the ordinary frame-received pulse when the last byte arrives, or withholds it when the frame is rejected.

The expected length comes from one of two places. It can come from the Type/Length word at bytes 12..13. For IPv4 (type 0x0800) and IPX (type 0x8137), each with its own enable, it comes from the 16-bit length field at bytes 16..17. Any other type value gives no early pulse. The distance before the end is set by `cfg_thresh` in units of 8 bytes, and a value of zero turns the early pulse off.

The FSM states are S_IDLE (between frames), S_HDR (bytes 0..13, classifying the Type/Length word), S_L3 (waiting for the L3 length at bytes 16..17), S_TRACK (length known, counting toward the early point) and S_DONE (pulse given or not possible, waiting for the end).

The transitions are as follows:
- A start strobe moves any state to S_HDR.
- In S_HDR, byte 13 moves to S_TRACK for a length, to S_L3 for an enabled IP/IPX type, or to S_DONE for any other type.
- In S_L3, byte 17 moves to S_TRACK.
- S_HDR, S_L3 or S_TRACK move to S_DONE when the early pulse fires.
- A final byte (`eof`) moves any state to S_IDLE.

Top module: `early_rx_irq`

## Requirements
- R1: The Type/Length word is bytes 12 (high) and 13 (low), counted from 0 after `sof`. A value of 0x05DC or below is a length, and the expected frame length is E = value + 14.
- R2: For type 0x0800 with `cfg_ip_en`=1, or type 0x8137 with `cfg_ipx_en`=1, E = {byte16, byte17} + 14. Any other value above 0x05DC, or either of these types with its enable clear, gives no early pulse.
- R3: With threshold T nonzero, `er_pulse` is high for one cycle, in the cycle after the first byte whose 1-based count n satisfies n + 8·T ≥ E, provided E is known at that byte.
- R4: `cfg_thresh` = 0 gives no early pulse.
- R5: When 8·T is large enough that the point falls before the length is known, the pulse follows byte 13 (length case) or byte 17 (IP/IPX case).
- R6: A frame that ends before the early point gives no early pulse. A frame during which `rx_ovr` was seen before the point gives no early pulse.
- R7: No early pulse is produced while `ru_ready` is low or `discard` is high, and no frame-received pulse is produced for such a frame.
- R8: `fr_pulse` is high for one cycle, in the cycle after the byte carrying `eof`, for every accepted frame, even after an early pulse. It may fall in the same cycle as `er_pulse`.
- R9: A frame is bad when `rx_err` is high on its `eof` byte or `rx_ovr` was seen during it. With `cfg_save_bad`=0 a bad frame gets no `fr_pulse`; with `cfg_save_bad`=1 it does.
- R10: At most one `er_pulse` is produced per frame, and `sof` clears all per-frame state.
- R11: After reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-frame strobe, in a cycle with no byte |
| byte_vld | input | 1 | A frame byte is present on byte_data |
| byte_data | input | 8 | Frame byte |
| eof | input | 1 | Marks the byte as the last one of the frame |
| rx_err | input | 1 | Frame error, sampled on the eof byte |
| rx_ovr | input | 1 | Overrun, sampled on every byte |
| ru_ready | input | 1 | Receive unit started |
| discard | input | 1 | Incoming frames are being dropped |
| cfg_thresh | input | 8 | Early distance in units of 8 bytes, 0 = off |
| cfg_ip_en | input | 1 | Take the length from the IPv4 header |
| cfg_ipx_en | input | 1 | Take the length from the IPX header |
| cfg_save_bad | input | 1 | Keep bad frames (1) or drop them (0) |
| er_pulse | output | 1 | Early-receive pulse |
| fr_pulse | output | 1 | Frame-received pulse |

## Verification
The early pulse and the frame-received pulse can land in the same cycle. This happens when a frame's final byte is exactly the byte that reaches the early point. The bench provokes it with a length-type frame (E = 114, T = 4) that is truncated to 82 bytes, so byte 81 both carries `eof` and satisfies the compare. It expects both pulses high together, once, in the cycle after that byte. The bench also checks the neighbouring case, where the point is never reached, and confirms that only `fr_pulse` appears.

// File: rtl/erx_pkg.sv
package erx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_L3,
        S_TRACK,
        S_DONE
    } erx_state_e;

    typedef enum logic [1:0] {
        TL_LEN,
        TL_L3,
        TL_OTHER
    } tl_kind_e;

    localparam logic [15:0] TL_MAX_LEN = 16'h05DC;
    localparam logic [15:0] TYPE_IP    = 16'h0800;
    localparam logic [15:0] TYPE_IPX   = 16'h8137;
    localparam int          HDR_BYTES  = 14;
    localparam int          TL_LO_IDX  = 13;
    localparam int          TL_HI_IDX  = 12;
    localparam int          L3_HI_IDX  = 16;
    localparam int          L3_LO_IDX  = 17;
endpackage

// File: rtl/erx_tl_classify.sv
module erx_tl_classify
    import erx_pkg::*;
(
    input  logic [15:0] tl_word,
    input  logic        ip_en,
    input  logic        ipx_en,
    output tl_kind_e    kind
);
    always_comb begin
        if (tl_word <= TL_MAX_LEN)
            kind = TL_LEN;
        else if ((tl_word == TYPE_IP && ip_en) || (tl_word == TYPE_IPX && ipx_en))
            kind = TL_L3;
        else
            kind = TL_OTHER;
    end
endmodule

// File: rtl/erx_point_cmp.sv
module erx_point_cmp #(
    parameter int CNT_W = 16,
    parameter int THR_W = 8
) (
    input  logic [CNT_W:0]   count_n,
    input  logic [CNT_W:0]   len_exp,
    input  logic [THR_W-1:0] thresh,
    output logic             reached
);
    localparam int SUM_W = CNT_W + 2;

    logic [SUM_W-1:0] reach_sum;

    always_comb begin
        reach_sum = SUM_W'(count_n) + (SUM_W'(thresh) << 3);
        reached   = reach_sum >= SUM_W'(len_exp);
    end
endmodule

// File: rtl/early_rx_irq.sv
module early_rx_irq
    import erx_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    input  logic             eof,
    input  logic             rx_err,
    input  logic             rx_ovr,
    input  logic             ru_ready,
    input  logic             discard,
    input  logic [THR_W-1:0] cfg_thresh,
    input  logic             cfg_ip_en,
    input  logic             cfg_ipx_en,
    input  logic             cfg_save_bad,
    output logic             er_pulse,
    output logic             fr_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    erx_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       tl_hi, l3_hi;
    logic [CNT_W:0]   exp_len, new_len, count_n;
    logic             ovr_seen, er_hit;
    logic             in_frame, at_tl_lo, at_l3_lo, len_now, gate, reached, fire, fr_nx;
    logic [15:0]      tl_word, l3_word;
    tl_kind_e         tl_kind;

    assign tl_word  = {tl_hi, byte_data};
    assign l3_word  = {l3_hi, byte_data};
    assign in_frame = (state != S_IDLE);
    assign at_tl_lo = byte_vld && (state == S_HDR) && (cnt == CNT_W'(TL_LO_IDX));
    assign at_l3_lo = byte_vld && (state == S_L3) && (cnt == CNT_W'(L3_LO_IDX));
    assign count_n  = {1'b0, cnt} + 1'b1;

    erx_tl_classify u_cls (
        .tl_word (tl_word),
        .ip_en   (cfg_ip_en),
        .ipx_en  (cfg_ipx_en),
        .kind    (tl_kind)
    );

    always_comb begin
        if (at_tl_lo)
            new_len = (CNT_W+1)'(tl_word) + (CNT_W+1)'(HDR_BYTES);
        else if (at_l3_lo)
            new_len = (CNT_W+1)'(l3_word) + (CNT_W+1)'(HDR_BYTES);
        else
            new_len = exp_len;
    end

    erx_point_cmp #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cmp (
        .count_n (count_n),
        .len_exp (new_len),
        .thresh  (cfg_thresh),
        .reached (reached)
    );

    assign len_now = (at_tl_lo && tl_kind == TL_LEN) || at_l3_lo
                     || (byte_vld && state == S_TRACK);
    assign gate    = (cfg_thresh != '0) && ru_ready && !discard && !ovr_seen && !rx_ovr;
    assign fire    = gate && len_now && reached && !er_hit;
    assign fr_nx   = byte_vld && eof && in_frame && ru_ready && !discard
                     && (cfg_save_bad || !(rx_err || rx_ovr || ovr_seen));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  state_nx = S_IDLE;
            S_HDR: begin
                if (at_tl_lo) begin
                    if (fire)                   state_nx = S_DONE;
                    else if (tl_kind == TL_LEN) state_nx = S_TRACK;
                    else if (tl_kind == TL_L3)  state_nx = S_L3;
                    else                        state_nx = S_DONE;
                end
            end
            S_L3:    if (at_l3_lo) state_nx = fire ? S_DONE : S_TRACK;
            S_TRACK: if (fire) state_nx = S_DONE;
            S_DONE:  state_nx = S_DONE;
            default: state_nx = S_IDLE;
        endcase
        if (byte_vld && eof && in_frame) state_nx = S_IDLE;
        if (sof)                         state_nx = S_HDR;
    end

    // state register and per-frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            tl_hi    <= '0;
            l3_hi    <= '0;
            exp_len  <= '0;
            ovr_seen <= 1'b0;
            er_hit   <= 1'b0;
        end else begin
            state <= state_nx;
            if (sof) begin
                cnt      <= '0;
                exp_len  <= '0;
                ovr_seen <= 1'b0;
                er_hit   <= 1'b0;
            end else if (byte_vld && in_frame) begin
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(TL_HI_IDX)) tl_hi <= byte_data;
                if (cnt == CNT_W'(L3_HI_IDX)) l3_hi <= byte_data;
                exp_len  <= new_len;
                ovr_seen <= ovr_seen | rx_ovr;
                er_hit   <= er_hit | fire;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            er_pulse <= 1'b0;
            fr_pulse <= 1'b0;
        end else begin
            er_pulse <= fire;
            fr_pulse <= fr_nx;
        end
    end

    p_er_needs_thresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
        er_pulse |-> $past(cfg_thresh) != '0);

    p_er_needs_rx_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        er_pulse |-> $past(ru_ready && !discard && byte_vld));

    p_fr_after_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fr_pulse |-> $past(byte_vld && eof));

    p_bad_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_pulse && !$past(cfg_save_bad)) |-> !$past(rx_err));

    p_single_er_r10: assert property (@(posedge clk) disable iff (!rst_n)
        er_pulse |=> !er_pulse);
endmodule

// File: tb/sim_early_rx_irq.sv
module sim_early_rx_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sof = 1'b0, byte_vld = 1'b0, eof = 1'b0;
    logic [7:0] byte_data = '0;
    logic       rx_err = 1'b0, rx_ovr = 1'b0, ru_ready = 1'b1, discard = 1'b0;
    logic [7:0] cfg_thresh = '0;
    logic       cfg_ip_en = 1'b0, cfg_ipx_en = 1'b0, cfg_save_bad = 1'b0;
    logic       er_pulse, fr_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    early_rx_irq u0 (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
        .byte_data(byte_data), .eof(eof), .rx_err(rx_err), .rx_ovr(rx_ovr),
        .ru_ready(ru_ready), .discard(discard), .cfg_thresh(cfg_thresh),
        .cfg_ip_en(cfg_ip_en), .cfg_ipx_en(cfg_ipx_en),
        .cfg_save_bad(cfg_save_bad), .er_pulse(er_pulse), .fr_pulse(fr_pulse)
    );

    typedef struct packed {
        logic [15:0] tl;
        logic [15:0] l3;
        logic [7:0]  thr;
        logic        ipen;
        logic        ipxen;
        logic [15:0] len;
        logic        sbf;
        logic        err;
        logic [15:0] er_idx;   // 16'hFFFF = no early pulse expected
        logic        fr;
    } vec_t;

    localparam vec_t TBL [14] = '{
        '{16'd100,   16'd0,  8'd4,   1'b0, 1'b0, 16'd114, 1'b0, 1'b0, 16'd81,    1'b1}, // R1 R3
        '{16'h0800,  16'd60, 8'd2,   1'b1, 1'b0, 16'd74,  1'b0, 1'b0, 16'd57,    1'b1}, // R2 IP
        '{16'h8137,  16'd40, 8'd1,   1'b0, 1'b1, 16'd54,  1'b0, 1'b0, 16'd45,    1'b1}, // R2 IPX
        '{16'h0800,  16'd60, 8'd2,   1'b0, 1'b1, 16'd74,  1'b0, 1'b0, 16'hFFFF,  1'b1}, // R2 IP disabled
        '{16'h86DD,  16'd0,  8'd2,   1'b1, 1'b1, 16'd60,  1'b0, 1'b0, 16'hFFFF,  1'b1}, // R2 other type
        '{16'd100,   16'd0,  8'd0,   1'b0, 1'b0, 16'd114, 1'b0, 1'b0, 16'hFFFF,  1'b1}, // R4
        '{16'd20,    16'd0,  8'd10,  1'b0, 1'b0, 16'd34,  1'b0, 1'b0, 16'd13,    1'b1}, // R5 length
        '{16'h0800,  16'd20, 8'd8,   1'b1, 1'b0, 16'd34,  1'b0, 1'b0, 16'd17,    1'b1}, // R5 IP
        '{16'd100,   16'd0,  8'd4,   1'b0, 1'b0, 16'd60,  1'b0, 1'b0, 16'hFFFF,  1'b1}, // R6 short
        '{16'd100,   16'd0,  8'd4,   1'b0, 1'b0, 16'd114, 1'b0, 1'b1, 16'd81,    1'b0}, // R9 drop bad
        '{16'd100,   16'd0,  8'd4,   1'b0, 1'b0, 16'd114, 1'b1, 1'b1, 16'd81,    1'b1}, // R9 save bad
        '{16'd100,   16'd0,  8'd4,   1'b0, 1'b0, 16'd82,  1'b0, 1'b0, 16'd81,    1'b1}, // R8 coincide
        '{16'h05DC,  16'd0,  8'd255, 1'b0, 1'b0, 16'd20,  1'b0, 1'b0, 16'd13,    1'b1}, // R1 edge len
        '{16'h05DD,  16'd0,  8'd255, 1'b1, 1'b1, 16'd20,  1'b0, 1'b0, 16'hFFFF,  1'b1}  // R1 edge type
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sends one frame; er/fr indices are the byte after which the pulse appeared.
    task automatic send_frame(input logic [15:0] tl, input logic [15:0] l3,
                              input int len, input bit err, input int ovr_at,
                              output int er_idx, output int er_cnt,
                              output int fr_idx, output int fr_cnt);
        er_idx = -1; er_cnt = 0; fr_idx = -1; fr_cnt = 0;
        @(negedge clk);
        sof = 1'b1;
        for (int k = 0; k <= len + 1; k++) begin
            @(negedge clk);
            if (er_pulse) begin er_cnt++; er_idx = k - 1; end
            if (fr_pulse) begin fr_cnt++; fr_idx = k - 1; end
            sof = 1'b0;
            if (k < len) begin
                byte_vld  = 1'b1;
                byte_data = (k == 12) ? tl[15:8] : (k == 13) ? tl[7:0] :
                            (k == 16) ? l3[15:8] : (k == 17) ? l3[7:0] : 8'(k);
                eof       = (k == len - 1);
                rx_err    = err && (k == len - 1);
                rx_ovr    = (k == ovr_at);
            end else begin
                byte_vld = 1'b0; eof = 1'b0; rx_err = 1'b0; rx_ovr = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ei, ec, fi, fc;
        repeat (3) @(negedge clk);
        chk(er_pulse == 1'b0 && fr_pulse == 1'b0, "R11 reset", int'(er_pulse | fr_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(er_pulse == 1'b0 && fr_pulse == 1'b0, "R11 after reset", int'(er_pulse | fr_pulse), 0);

        for (int v = 0; v < 14; v++) begin
            cfg_thresh   = TBL[v].thr;
            cfg_ip_en    = TBL[v].ipen;
            cfg_ipx_en   = TBL[v].ipxen;
            cfg_save_bad = TBL[v].sbf;
            send_frame(TBL[v].tl, TBL[v].l3, int'(TBL[v].len), TBL[v].err, -1, ei, ec, fi, fc);
            if (TBL[v].er_idx == 16'hFFFF) begin
                chk(ec == 0, $sformatf("R3 vec%0d no early", v), ec, 0);
            end else begin
                chk(ec == 1, $sformatf("R10 vec%0d early count", v), ec, 1);
                chk(ei == int'(TBL[v].er_idx), $sformatf("R3 vec%0d early byte", v), ei, int'(TBL[v].er_idx));
            end
            chk(fc == int'(TBL[v].fr), $sformatf("R8 vec%0d fr count", v), fc, int'(TBL[v].fr));
            if (TBL[v].fr)
                chk(fi == int'(TBL[v].len) - 1, $sformatf("R8 vec%0d fr byte", v), fi, int'(TBL[v].len) - 1);
        end

        // R7: receive unit stopped
        cfg_thresh = 8'd4; cfg_save_bad = 1'b0; cfg_ip_en = 1'b0; cfg_ipx_en = 1'b0;
        ru_ready = 1'b0;
        send_frame(16'd100, 16'd0, 114, 1'b0, -1, ei, ec, fi, fc);
        chk(ec == 0, "R7 ru stopped early", ec, 0);
        chk(fc == 0, "R7 ru stopped fr", fc, 0);
        ru_ready = 1'b1;

        // R7: discarding
        discard = 1'b1;
        send_frame(16'd100, 16'd0, 114, 1'b0, -1, ei, ec, fi, fc);
        chk(ec == 0, "R7 discard early", ec, 0);
        chk(fc == 0, "R7 discard fr", fc, 0);
        discard = 1'b0;

        // R6/R9: overrun before the point
        send_frame(16'd100, 16'd0, 114, 1'b0, 40, ei, ec, fi, fc);
        chk(ec == 0, "R6 overrun early", ec, 0);
        chk(fc == 0, "R9 overrun dropped", fc, 0);

        // R10: sof clears state, next frame fires normally
        send_frame(16'd100, 16'd0, 114, 1'b0, -1, ei, ec, fi, fc);
        chk(ec == 1 && ei == 81, "R10 after overrun frame", ei, 81);

        // R10: sof mid-frame restarts the count
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0; byte_vld = 1'b1; byte_data = 8'h00;
        repeat (30) @(negedge clk);
        byte_vld = 1'b0;
        send_frame(16'd20, 16'd0, 34, 1'b0, -1, ei, ec, fi, fc);
        chk(ec == 1 && ei == 13, "R10 restart early byte", ei, 13);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule